// File: doc/BRIEF.md
# Homogeneous Automaton Matching Engine

This block runs a configurable non-deterministic automaton of the homogeneous kind over a stream of fixed-width input symbols. In this model each state owns a set of symbols, its symbol class. A state can become active only when the current symbol is in its class and at least one state that routes into it is active. The engine stores three configuration matrices: the symbol classes, the routing between states, and the set of accepting states. It also stores a start set. Every symbol step is two OR-of-AND products, one for the symbol match and one for the reachable states, followed by a bitwise AND.

Software loads the configuration one row at a time through a small write port while the engine is idle. A start pulse seeds the active set from the start register. After that, one symbol is taken on each clock in which the valid input is high. The active set and the accept flag update together on the same edge. A symbol marked as last ends the stream, and the accept result of that final step is held until the next start.

Top module: `nfa_engine`

## Requirements
- R1: After reset the active set, accept flag, busy, done and final-accept outputs are all zero, and every configuration row reads as zero.
- R2: A symbol with value k is in the class of state n exactly when bit n of class row k is 1. Class rows are written with select code 0 and row index k.
- R3: State n is reachable from state i exactly when bit i of routing row n is 1. Routing rows are written with select code 1 and row index n.
- R4: On each consumed symbol the new active set is the AND of two vectors: the states reachable from the current active set, and the states whose class contains the symbol.
- R5: The accept output is 1 exactly when the active set registered on the same edge overlaps the accepting set. The accepting set is written with select code 2.
- R6: A start pulse loads the active set from the start register (select code 3). It sets busy, clears done and final-accept, and computes accept from the start set. A start pulse also restarts a stream that is already running.
- R7: While busy, one symbol is consumed per clock in which valid is high. A clock without valid leaves the active set and the accept output unchanged.
- R8: Configuration writes made while busy are dropped, and later steps still use the old rows.
- R9: A consumed symbol with last set clears busy, sets done and latches that step's accept value into final-accept, which then holds until the next start.
- R10: Symbols presented while the engine is idle are ignored. Configuration persists across streams until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration row write strobe |
| cfg_sel_i | input | 2 | Target matrix: 0 class, 1 routing, 2 accept, 3 start |
| cfg_row_i | input | ROW_W | Row index for class or routing writes |
| cfg_data_i | input | NST | Row bits, one per state |
| start_i | input | 1 | Begin a stream from the start set |
| sym_valid_i | input | 1 | Symbol present this cycle |
| sym_i | input | SYM_W | Input symbol |
| sym_last_i | input | 1 | Symbol ends the stream |
| active_o | output | NST | Current active set |
| accept_o | output | 1 | Active set contains an accepting state |
| busy_o | output | 1 | Stream in progress |
| done_o | output | 1 | Stream finished |
| final_accept_o | output | 1 | Accept result of the last symbol |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the middle of a stream. Dropping it only shows up if the old and new rows would give different outputs on a later symbol. The stimulus therefore starts a stream, rewrites the accepting set while busy, and then feeds a symbol whose resulting active set is accepting under the new set but not under the old one. It then ends the stream, writes the same row while idle, and confirms that this time the write takes effect on the next start.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [1:0] {
    CFG_CLASS  = 2'd0,
    CFG_ROUTE  = 2'd1,
    CFG_ACCEPT = 2'd2,
    CFG_START  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/nfa_cfg_store.sv
module nfa_cfg_store #(
  parameter int SYM_W = 2,
  parameter int NST   = 4,
  parameter int ROW_W = 2,
  localparam int NSYM = 1 << SYM_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       busy_i,
  input  logic                       we_i,
  input  logic [1:0]                 sel_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [NST-1:0]             data_i,
  output logic [NSYM-1:0][NST-1:0]   class_o,
  output logic [NST-1:0][NST-1:0]    route_o,
  output logic [NST-1:0]             acc_o,
  output logic [NST-1:0]             start_o
);
  import nfa_pkg::*;

  logic wr_ok;
  assign wr_ok = we_i & ~busy_i;

  for (genvar k = 0; k < NSYM; k++) begin : g_class
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) class_o[k] <= '0;
      else if (wr_ok && sel_i == CFG_CLASS && row_i == ROW_W'(k)) class_o[k] <= data_i;
    end
  end

  for (genvar n = 0; n < NST; n++) begin : g_route
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_o[n] <= '0;
      else if (wr_ok && sel_i == CFG_ROUTE && row_i == ROW_W'(n)) route_o[n] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      start_o <= '0;
    end else if (wr_ok) begin
      if (sel_i == CFG_ACCEPT) acc_o   <= data_i;
      if (sel_i == CFG_START)  start_o <= data_i;
    end
  end

  AST_CFG_FROZEN_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(acc_o)) else $error("accept row changed while busy"); // R8
  AST_CFG_FROZEN_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(route_o)) else $error("routing changed while busy"); // R8
endmodule

// File: rtl/nfa_sym_match.sv
module nfa_sym_match #(
  parameter int SYM_W = 2,
  parameter int NST   = 4,
  localparam int NSYM = 1 << SYM_W
) (
  input  logic [SYM_W-1:0]           sym_i,
  input  logic [NSYM-1:0][NST-1:0]   class_i,
  output logic [NST-1:0]             match_o
);
  logic [NSYM-1:0] line;

  always_comb begin
    line = '0;
    line[sym_i] = 1'b1;
  end

  // per state: OR over lines of (selected line AND class bit)
  for (genvar n = 0; n < NST; n++) begin : g_state
    always_comb begin
      match_o[n] = 1'b0;
      for (int k = 0; k < NSYM; k++) match_o[n] = match_o[n] | (line[k] & class_i[k][n]);
    end
  end
endmodule

// File: rtl/nfa_route.sv
module nfa_route #(
  parameter int NST = 4
) (
  input  logic [NST-1:0]           active_i,
  input  logic [NST-1:0][NST-1:0]  route_i,
  output logic [NST-1:0]           follow_o
);
  for (genvar n = 0; n < NST; n++) begin : g_dst
    assign follow_o[n] = |(active_i & route_i[n]);
  end
endmodule

// File: rtl/nfa_engine.sv
module nfa_engine #(
  parameter int SYM_W = 2,
  parameter int NST   = 4,
  localparam int NSYM  = 1 << SYM_W,
  localparam int ROW_W = (SYM_W > $clog2(NST)) ? SYM_W : $clog2(NST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ROW_W-1:0]  cfg_row_i,
  input  logic [NST-1:0]    cfg_data_i,
  input  logic              start_i,
  input  logic              sym_valid_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic              sym_last_i,
  output logic [NST-1:0]    active_o,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              final_accept_o
);
  logic [NSYM-1:0][NST-1:0] class_q;
  logic [NST-1:0][NST-1:0]  route_q;
  logic [NST-1:0]           acc_q, start_q, match, follow, nxt;
  logic                     nxt_acc, step;

  nfa_cfg_store #(.SYM_W(SYM_W), .NST(NST), .ROW_W(ROW_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy_o),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .row_i   (cfg_row_i),
    .data_i  (cfg_data_i),
    .class_o (class_q),
    .route_o (route_q),
    .acc_o   (acc_q),
    .start_o (start_q)
  );

  nfa_sym_match #(.SYM_W(SYM_W), .NST(NST)) u_match (
    .sym_i   (sym_i),
    .class_i (class_q),
    .match_o (match)
  );

  nfa_route #(.NST(NST)) u_route (
    .active_i (active_o),
    .route_i  (route_q),
    .follow_o (follow)
  );

  assign nxt     = follow & match;
  assign nxt_acc = |(nxt & acc_q);
  assign step    = busy_o & sym_valid_i & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o       <= '0;
      accept_o       <= 1'b0;
      busy_o         <= 1'b0;
      done_o         <= 1'b0;
      final_accept_o <= 1'b0;
    end else if (start_i) begin
      active_o       <= start_q;
      accept_o       <= |(start_q & acc_q);
      busy_o         <= 1'b1;
      done_o         <= 1'b0;
      final_accept_o <= 1'b0;
    end else if (step) begin
      active_o <= nxt;
      accept_o <= nxt_acc;
      if (sym_last_i) begin
        busy_o         <= 1'b0;
        done_o         <= 1'b1;
        final_accept_o <= nxt_acc;
      end
    end
  end

  AST_NEXT_WITHIN_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> (active_o & ~$past(follow)) == '0) else $error("state entered without route"); // R4
  AST_NEXT_WITHIN_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> (active_o & ~$past(match)) == '0) else $error("state entered off class"); // R2
  AST_ACCEPT_CONSISTENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> accept_o == |(active_o & acc_q)) else $error("accept mismatch"); // R5
  AST_HOLD_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sym_valid_i && !start_i) |=> $stable(active_o) && $stable(accept_o))
    else $error("active set moved without symbol"); // R7
  AST_IDLE_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(active_o)) else $error("idle symbol consumed"); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !busy_o) else $error("done while busy"); // R9
endmodule

// File: tb/nfa_engine_test.sv
module nfa_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [1:0] cfg_row = '0;
  logic [3:0] cfg_data = '0;
  logic       start = 1'b0, vld = 1'b0, last = 1'b0;
  logic [1:0] sym = '0;
  logic [3:0] active;
  logic       accept, busy, done, facc;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nfa_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_row_i(cfg_row), .cfg_data_i(cfg_data), .start_i(start),
    .sym_valid_i(vld), .sym_i(sym), .sym_last_i(last), .active_o(active),
    .accept_o(accept), .busy_o(busy), .done_o(done), .final_accept_o(facc)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [1:0] r, input logic [3:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_row = r; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic st, input logic v, input logic [1:0] s, input logic l);
    start = st; vld = v; sym = s; last = l;
    @(negedge clk);
    start = 1'b0; vld = 1'b0; last = 1'b0;
  endtask

  // {start, valid, sym[1:0], last, exp_active[3:0], exp_accept}
  // states S1..S3 = bits 0..2; symbols a=0 b=1 c=2 d=3
  localparam logic [9:0] TBL [9] = '{
    {1'b1, 1'b0, 2'd0, 1'b0, 4'b0001, 1'b0},
    {1'b0, 1'b1, 2'd1, 1'b0, 4'b0011, 1'b0},
    {1'b0, 1'b1, 2'd2, 1'b0, 4'b0101, 1'b1},
    {1'b0, 1'b1, 2'd0, 1'b0, 4'b0001, 1'b0},
    {1'b0, 1'b1, 2'd3, 1'b0, 4'b0000, 1'b0},
    {1'b1, 1'b0, 2'd0, 1'b0, 4'b0001, 1'b0},
    {1'b0, 1'b1, 2'd2, 1'b0, 4'b0101, 1'b1},
    {1'b0, 1'b0, 2'd1, 1'b0, 4'b0101, 1'b1},
    {1'b0, 1'b1, 2'd1, 1'b1, 4'b0011, 1'b0}
  };

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 active", active, 4'b0000);
    chk("R1 accept", {3'b0, accept}, 4'd0);
    chk("R1 busy", {3'b0, busy}, 4'd0);
    chk("R1 done", {3'b0, done}, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 empty config: start set zero gives empty active set
    cyc(1, 0, 0, 0);
    chk("R1 empty start", active, 4'b0000);
    cyc(0, 1, 0, 1);
    // R2 class rows, R3 routing rows
    wr(2'd0, 2'd0, 4'b0001);
    wr(2'd0, 2'd1, 4'b0011);
    wr(2'd0, 2'd2, 4'b0101);
    wr(2'd0, 2'd3, 4'b0000);
    wr(2'd1, 2'd0, 4'b0001);
    wr(2'd1, 2'd1, 4'b0001);
    wr(2'd1, 2'd2, 4'b0011);
    wr(2'd1, 2'd3, 4'b0000);
    wr(2'd2, 2'd0, 4'b0100);
    wr(2'd3, 2'd0, 4'b0001);
    // R2 R3 R4 R5 R6 R7 R9 table walk
    for (int i = 0; i < 9; i++) begin
      cyc(TBL[i][9], TBL[i][8], TBL[i][7:6], TBL[i][5]);
      chk("R4 table active", active, TBL[i][4:1]);
      chk("R5 table accept", {3'b0, accept}, {3'b0, TBL[i][0]});
    end
    chk("R9 done", {3'b0, done}, 4'd1);
    chk("R9 busy cleared", {3'b0, busy}, 4'd0);
    chk("R9 final reject", {3'b0, facc}, 4'd0);
    // R9 accepting last symbol
    cyc(1, 0, 0, 0);
    chk("R6 busy", {3'b0, busy}, 4'd1);
    chk("R6 done cleared", {3'b0, done}, 4'd0);
    cyc(0, 1, 2'd2, 1);
    chk("R9 final accept", {3'b0, facc}, 4'd1);
    // R10 idle symbols ignored
    cyc(0, 1, 2'd1, 0);
    chk("R10 idle active", active, 4'b0101);
    chk("R9 final held", {3'b0, facc}, 4'd1);
    // R8 write while busy dropped
    cyc(1, 0, 0, 0);
    wr(2'd2, 2'd0, 4'b0001);
    cyc(0, 1, 2'd1, 0);
    chk("R8 active", active, 4'b0011);
    chk("R8 old accept row", {3'b0, accept}, 4'd0);
    cyc(0, 1, 2'd1, 1);
    // R10 persistence and R6 accept from start set after idle write
    cyc(1, 0, 0, 0);
    chk("R10 persists", {3'b0, accept}, 4'd0);
    cyc(0, 1, 2'd0, 1);
    wr(2'd2, 2'd0, 4'b0001);
    cyc(1, 0, 0, 0);
    chk("R6 start accept", {3'b0, accept}, 4'd1);
    // R6 restart mid-stream with new start set
    wr(2'd3, 2'd0, 4'b0010);
    cyc(0, 1, 2'd1, 0);
    chk("R8 start row frozen", active, 4'b0011);
    cyc(1, 0, 0, 0);
    chk("R6 restart old start", active, 4'b0001);
    cyc(0, 1, 2'd3, 1);
    wr(2'd3, 2'd0, 4'b0010);
    cyc(1, 0, 0, 0);
    chk("R6 new start", active, 4'b0010);
    // R3 S2 has no route into itself; S2 alone with b dies
    cyc(0, 1, 2'd1, 0);
    chk("R3 no self route", active, 4'b0000);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule